// File: doc/BRIEF.md
# Mode-Programmable Byte Port with Service-Request Handshake

This block is an 8-bit parallel port whose direction is chosen by a static `mode` pin. With `mode` at 0 it acts as an input port: a peripheral strobes a byte in, a service-request flag tells the processor that data is waiting, and the processor reads the byte by selecting the port. With `mode` at 1 it acts as an output port: the processor strobes a byte in while it selects the port, the byte is driven to the peripheral at all times, and the flag signals the handshake once the processor deselects the port.

The block runs on a fast system clock. The strobe and the two select pins pass through a synchronizer. A high synchronized strobe opens a load window, and its falling edge produces a one-cycle event. Tristate is modelled as `dout` plus `dout_oe`, with `dout` forced to zero while the drivers are off.

The flag is a two-state machine, `flag_state_t`.
- `FLAG_RAISED`: `srq` is 1.
- `FLAG_DROPPED`: `srq` is 0.

The transitions are as follows.
- **T_STROBE**: the strobe falling event moves the machine from `FLAG_RAISED` to `FLAG_DROPPED`. If the machine is already in `FLAG_DROPPED`, it stays there.
- **T_RELEASE**: a selected-to-deselected transition moves the machine from `FLAG_DROPPED` to `FLAG_RAISED`. If a strobe event occurs in the same cycle, the strobe event wins.
- **T_CLEAR**: `clr` or `rst` forces the machine to `FLAG_RAISED` in input mode and to `FLAG_DROPPED` in output mode.

Top module: `byte_hs_port`

## Requirements
- R1: After `rst` or `clr`, `srq` is 1 in input mode (`mode`=0) and 0 in output mode (`mode`=1), and the data register holds 0x00.
- R2: In input mode, the register takes `din` on every clock edge while the synchronized strobe is high. When the strobe falls, the register keeps the last byte taken.
- R3: A synchronized falling edge of the strobe drives `srq` to 0. A strobe that falls just before rising clock edge k shows `srq`=0 after edge k+2.
- R4: In input mode, `dout_oe` is 1 exactly when the synchronized `sel_a` and `sel_b` are both 1. `dout` then shows the register; otherwise `dout` reads 0x00.
- R5: In input mode, a change from selected (`sel_a`=1 and `sel_b`=1) to deselected sets `srq` to 1. A strobe falling event in the same cycle takes precedence and sets `srq` to 0.
- R6: In output mode, `dout_oe` is always 1 and `dout` always shows the register.
- R7: In output mode, the register loads `din` only while `sel_a`=0, `sel_b`=1 and the strobe is high. A strobe given while the port is deselected leaves `dout` unchanged.
- R8: In output mode, a change from selected to deselected (`sel_a`=1 or `sel_b`=0) sets `srq` to 1. The next strobe falling event returns `srq` to 0, whether the port is selected or not.
- R9: `clr` takes priority over a load and over any flag update in the same cycle. A strobe that falls while `clr` is held leaves the cleared state in place.
- R10: `stb`, `sel_a` and `sel_b` each pass through SYNC_STAGES flops (2 by default). A strobe raised before edge 1 loads the register at edge 3, and `dout` is unchanged after edge 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous system reset, active high |
| clr | input | 1 | Port clear, active high, synchronous to `clk` |
| mode | input | 1 | 0 = input port, 1 = output port |
| sel_a | input | 1 | First select; active high in input mode, active low in output mode |
| sel_b | input | 1 | Second select, active high |
| stb | input | 1 | Strobe: high opens the load window, falling edge latches |
| din | input | WIDTH | Data in |
| dout | output | WIDTH | Data out, 0 while `dout_oe` is 0 |
| dout_oe | output | 1 | Output driver enable |
| srq | output | 1 | Service-request flag |

## Verification
A wrong flag state shows on `srq` one cycle after the event that caused it. A wrong register value shows on `dout` at once in output mode, but in input mode only once the port is selected. For that reason the bench selects the port after every input-mode load. Each clock, a behavioural reference model predicts `dout`, `dout_oe` and `srq`, so any divergence is reported in the cycle it first reaches a port. Directed checks at fixed edge counts catch a wrong synchronizer depth or a wrong priority between clear, strobe and deselect.

// File: rtl/byte_port_pkg.sv
package byte_port_pkg;
    typedef enum logic [0:0] {
        FLAG_RAISED  = 1'b0,
        FLAG_DROPPED = 1'b1
    } flag_state_t;

    function automatic flag_state_t cleared_state(input logic out_mode);
        return out_mode ? FLAG_DROPPED : FLAG_RAISED;
    endfunction
endpackage

// File: rtl/bp_sync.sv
module bp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bp_events.sv
module bp_events (
    input  logic clk,
    input  logic rst,
    input  logic stb_s,
    input  logic sel_s,
    output logic fall_evt,
    output logic desel_evt
);
    logic stb_prev;
    logic sel_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_prev <= 1'b0;
            sel_prev <= 1'b0;
        end else begin
            stb_prev <= stb_s;
            sel_prev <= sel_s;
        end
    end

    assign fall_evt  = stb_prev & ~stb_s;
    assign desel_evt = sel_prev & ~sel_s;
endmodule

// File: rtl/bp_data_reg.sv
module bp_data_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else if (load)  q <= din;
    end

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

    assert_hold_no_load_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && !clr) |=> $stable(q));
endmodule

// File: rtl/bp_flag_fsm.sv
module bp_flag_fsm
    import byte_port_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic mode,
    input  logic fall_evt,
    input  logic desel_evt,
    output logic srq
);
    flag_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst || clr) state <= cleared_state(mode);
        else            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FLAG_RAISED:  if (fall_evt) state_nx = FLAG_DROPPED;
            FLAG_DROPPED: if (desel_evt && !fall_evt) state_nx = FLAG_RAISED;
            default:      state_nx = FLAG_RAISED;
        endcase
    end

    always_comb begin
        srq = (state == FLAG_RAISED);
    end

    assert_fall_low_R3: assert property (@(posedge clk) disable iff (rst)
        (fall_evt && !clr) |=> !srq);

    assert_desel_high_R5: assert property (@(posedge clk) disable iff (rst)
        (desel_evt && !fall_evt && !clr) |=> srq);

    assert_clear_flag_R1: assert property (@(posedge clk) disable iff (rst)
        clr |=> (srq == !$past(mode)));

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!fall_evt && !desel_evt && !clr) |=> $stable(srq));
endmodule

// File: rtl/byte_hs_port.sv
module byte_hs_port #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             mode,
    input  logic             sel_a,
    input  logic             sel_b,
    input  logic             stb,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe,
    output logic             srq
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw_ctl, sync_ctl;
    logic              stb_s, sel_a_s, sel_b_s;
    logic              selected, load_en;
    logic              fall_evt, desel_evt;
    logic [WIDTH-1:0]  data_q;

    assign raw_ctl = {stb, sel_a, sel_b};

    bp_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_ctl),
        .q   (sync_ctl)
    );

    assign {stb_s, sel_a_s, sel_b_s} = sync_ctl;

    always_comb begin
        if (mode) selected = ~sel_a_s & sel_b_s;
        else      selected =  sel_a_s & sel_b_s;
        load_en = stb_s & (~mode | selected);
        dout_oe = mode | selected;
        dout    = dout_oe ? data_q : '0;
    end

    bp_events u_events (
        .clk       (clk),
        .rst       (rst),
        .stb_s     (stb_s),
        .sel_s     (selected),
        .fall_evt  (fall_evt),
        .desel_evt (desel_evt)
    );

    bp_data_reg #(.WIDTH(WIDTH)) u_data (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .load (load_en),
        .din  (din),
        .q    (data_q)
    );

    bp_flag_fsm u_flag (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .mode      (mode),
        .fall_evt  (fall_evt),
        .desel_evt (desel_evt),
        .srq       (srq)
    );

    assert_out_mode_drive_R6: assert property (@(posedge clk) disable iff (rst)
        mode |-> (dout_oe && dout == data_q));

    assert_off_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> (dout == '0));
endmodule

// File: tb/sim_byte_hs_port.sv
module sim_byte_hs_port;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1, clr = 1'b0, mode = 1'b0;
    logic sel_a = 1'b0, sel_b = 1'b0, stb = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic dout_oe, srq;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_hs_port #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .clr(clr), .mode(mode), .sel_a(sel_a),
        .sel_b(sel_b), .stb(stb), .din(din), .dout(dout),
        .dout_oe(dout_oe), .srq(srq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model: delay lines held as queues
    bit   q_stb[$], q_a[$], q_b[$];
    bit   m_stb_old, m_sel_old, m_srq;
    logic [W-1:0] m_reg;

    function automatic bit m_selected(input bit a, input bit b);
        return mode ? (!a && b) : (a && b);
    endfunction

    initial begin
        q_stb = '{0, 0}; q_a = '{0, 0}; q_b = '{0, 0};
        m_reg = '0; m_srq = 1'b1; m_stb_old = 0; m_sel_old = 0;
    end

    always @(posedge clk) begin
        bit s_now, sel_now, fall, desel;
        s_now   = q_stb[1];
        sel_now = m_selected(q_a[1], q_b[1]);
        fall    = m_stb_old && !s_now;
        desel   = m_sel_old && !sel_now;
        if (rst) begin
            q_stb = '{0, 0}; q_a = '{0, 0}; q_b = '{0, 0};
            m_stb_old = 0; m_sel_old = 0; m_reg = '0; m_srq = !mode;
        end else begin
            if (clr) begin
                m_reg = '0; m_srq = !mode;
            end else begin
                if (s_now && (!mode || sel_now)) m_reg = din;
                if (fall) m_srq = 1'b0;
                else if (desel) m_srq = 1'b1;
            end
            m_stb_old = s_now;
            m_sel_old = sel_now;
            q_stb.push_front(stb);  void'(q_stb.pop_back());
            q_a.push_front(sel_a);  void'(q_a.pop_back());
            q_b.push_front(sel_b);  void'(q_b.pop_back());
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit oe_exp;
            oe_exp = mode ? 1'b1 : (q_a[1] && q_b[1]);
            chk("R4 R6 model dout_oe", dout_oe, oe_exp);
            chk("R2 R7 model dout", dout, oe_exp ? m_reg : '0);
            chk("R3 R5 R8 model srq", srq, m_srq);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1 reset srq input mode", srq, 1);
        chk("R1 reset dout_oe", dout_oe, 0);
        chk("R1 reset dout", dout, 8'h00);

        // input mode load with peripheral strobe, port deselected
        stb = 1; din = 8'hA5; tick(4);
        din = 8'h3C; sel_a = 1; tick(2);   // select change during high strobe
        sel_a = 0; stb = 0; tick(4);
        chk("R3 srq low after strobe", srq, 0);
        sel_a = 1; sel_b = 1; tick(3);
        chk("R4 oe when selected", dout_oe, 1);
        chk("R2 held byte", dout, 8'h3C);
        sel_a = 0; tick(3);
        chk("R5 srq high after deselect", srq, 1);
        chk("R4 oe off deselected", dout_oe, 0);
        chk("R4 dout zero deselected", dout, 8'h00);

        // clear held across a strobe and its falling edge
        stb = 1; din = 8'h77; clr = 1; tick(4);
        stb = 0; tick(4);
        clr = 0; tick(1);
        chk("R9 srq after clear over strobe", srq, 1);
        sel_a = 1; sel_b = 1; tick(3);
        chk("R9 register cleared", dout, 8'h00);

        // mode change under clear
        mode = 1; clr = 1; tick(2);
        clr = 0; tick(1);
        chk("R1 clear srq output mode", srq, 0);
        chk("R6 oe in output mode", dout_oe, 1);
        chk("R1 clear dout output mode", dout, 8'h00);

        // output mode, deselected strobe does not load
        stb = 1; din = 8'h5A; tick(3);
        stb = 0; tick(4);
        chk("R7 no load deselected", dout, 8'h00);
        sel_a = 0; tick(1);
        stb = 1; din = 8'hC3; tick(3);
        stb = 0; tick(4);
        chk("R7 load when selected", dout, 8'hC3);
        chk("R8 srq low after strobe", srq, 0);
        sel_a = 1; tick(4);
        chk("R8 srq high on deselect", srq, 1);
        stb = 1; din = 8'hFF; tick(2);
        stb = 0; tick(4);
        chk("R8 srq low on next strobe", srq, 0);
        chk("R7 dout kept", dout, 8'hC3);

        // synchronizer latency
        sel_a = 0; tick(4);
        stb = 1; din = 8'h11; tick(2);
        chk("R10 not loaded after two edges", dout, 8'hC3);
        tick(1);
        chk("R10 loaded after three edges", dout, 8'h11);
        stb = 0; tick(4);

        // system reset in output mode
        rst = 1; tick(2);
        rst = 0; tick(1);
        chk("R1 reset srq output mode", srq, 0);
        chk("R1 reset dout output mode", dout, 8'h00);
        chk("R6 reset oe output mode", dout_oe, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule